// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a physical page through a small table of block-translation entries. There are two independent tables of four entries each: one used for instruction fetches and one used for data accesses. Every entry is a pair of 32-bit words. The first word is the match word. It holds the effective tag, a block-length field and two privilege-valid bits. The second word is the result word. It holds the physical tag and a two-bit permission field.

Software loads the entries through a one-word write port. The lookup itself is combinational over the stored table. For the access presented, the block reports whether an entry hit, the translated physical page number, and a read/write permission pair. The block-length field acts as a mask over address bits 27:17. This lets one entry cover anything from 128 KiB up to 256 MiB. On a miss, hit stays low so that a page-table walk elsewhere can take over.

Top module: `bat_xlate`

## Requirements
- R1: After a synchronous active-low reset every word of both tables is zero, so no lookup hits until software writes an entry.
- R2: A write with `wr_en` high stores `wr_data` at the next rising clock edge. `wr_code`=1 selects the instruction table and 0 selects the data table. `wr_idx` selects the entry. `wr_lower`=1 selects the result word and 0 selects the match word.
- R3: An entry can match only when effective address bits 31:28 equal match-word bits 31:28.
- R4: Match-word bits 12:2 form an 11-bit length mask over address bits 27:17, with bit 2 masking address bit 17. Address bits 27:17 with the masked positions cleared must equal match-word bits 27:17.
- R5: For a supervisor access (`is_user`=0) an entry is usable only if match-word bit 1 is set. For a user access (`is_user`=1) it is usable only if match-word bit 0 is set.
- R6: On a hit, `pa_page` (physical address bits 31:12) is built from three parts. Its bits 31:28 are result-word bits 31:28. Its bits 27:17 are (address bits 27:17 AND mask) OR result-word bits 27:17. Its bits 16:12 are address bits 16:12.
- R7: On a hit, result-word bit 1 set grants read and write. Otherwise result-word bit 0 set grants read only. With both bits clear the lookup still hits but grants neither read nor write.
- R8: When several entries match, the one with the lowest index decides the result.
- R9: `is_code`=1 looks up only the instruction table and `is_code`=0 looks up only the data table.
- R10: With no usable matching entry, `hit`, `rd_ok` and `wr_ok` are 0 and `pa_page` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_code | input | 1 | Write target table: 1 instruction, 0 data |
| wr_idx | input | 2 | Entry index for the write |
| wr_lower | input | 1 | Word select: 1 result word, 0 match word |
| wr_data | input | 32 | Word to store |
| ea | input | 32 | Effective address to translate |
| is_code | input | 1 | Access is an instruction fetch |
| is_user | input | 1 | Access runs in user mode |
| hit | output | 1 | A usable entry matched |
| pa_page | output | 20 | Physical address bits 31:12 |
| rd_ok | output | 1 | Read permitted |
| wr_ok | output | 1 | Write permitted |

## Verification
The assertions are sampled on the rising clock edge. They assume that `ea`, `is_code` and `is_user` are stable around that edge, since the lookup path is purely combinational. The bench meets this by changing the inputs only on the falling edge and sampling outputs shortly afterwards. The assertions also assume that `wr_idx` always addresses an existing entry. The bench draws indices only from the valid range. Random entries use contiguous low-order length masks and mostly clear tag bits, and lookup addresses are mostly derived from a stored entry, so hits, overlaps and misses all occur often.

// File: rtl/bat_xlate_pkg.sv
// Package: shared field positions and the lookup result type of the
// block address translation matcher. Field positions are fixed by the
// entry word layout; only the entry count is a parameter of the top.
package bat_xlate_pkg;

    localparam int WORD_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = WORD_W - PAGE_LSB;   // 20 bits of page number

    // Effective tag compared exactly
    localparam int TAG_HI   = 31;
    localparam int TAG_LO   = 28;
    // Middle bits subject to the length mask
    localparam int MID_HI   = 27;
    localparam int MID_LO   = 17;
    localparam int MID_W    = MID_HI - MID_LO + 1;  // 11
    // Length mask position in the match word
    localparam int LEN_HI   = 12;
    localparam int LEN_LO   = 2;
    // Privilege-valid bits in the match word
    localparam int SUP_BIT  = 1;
    localparam int USR_BIT  = 0;
    // Permission bits in the result word
    localparam int RW_BIT   = 1;
    localparam int RO_BIT   = 0;

    // Result of one entry or of the whole lookup
    typedef struct packed {
        logic              hit;
        logic              rd;
        logic              wr;
        logic [PAGE_W-1:0] page;
    } xlate_res_t;

endpackage

// File: rtl/bat_regs.sv
// Module: bat_regs
// Holds the two translation tables (instruction and data), each with
// N_ENT pairs of match/result words. One word is written per cycle.
// The read side presents the table chosen by rd_code combinationally.
// Assumes wr_idx addresses an existing entry.
module bat_regs
    import bat_xlate_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_code,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_lower,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_code,
    output logic [WORD_W-1:0] match_w [N_ENT],
    output logic [WORD_W-1:0] res_w   [N_ENT]
);

    localparam int N_SET = 2;

    logic [WORD_W-1:0] match_q [N_SET][N_ENT];
    logic [WORD_W-1:0] res_q   [N_SET][N_ENT];

    // Table storage: clear on reset, otherwise accept one word write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SET; s++) begin
                for (int e = 0; e < N_ENT; e++) begin
                    match_q[s][e] <= '0;
                    res_q[s][e]   <= '0;
                end
            end
        end else if (wr_en) begin
            if (wr_lower) begin
                res_q[wr_code][wr_idx]   <= wr_data;
            end else begin
                match_q[wr_code][wr_idx] <= wr_data;
            end
        end
    end

    // Read side: present the table belonging to the access type
    always_comb begin
        for (int e = 0; e < N_ENT; e++) begin
            match_w[e] = match_q[rd_code][e];
            res_w[e]   = res_q[rd_code][e];
        end
    end

endmodule

// File: rtl/bat_entry_cmp.sv
// Module: bat_entry_cmp
// Compares one effective address against one match/result word pair.
// It produces the match flag and the translated page and permissions.
// Purely combinational; assumes the caller picks among entries.
module bat_entry_cmp
    import bat_xlate_pkg::*;
(
    input  logic [WORD_W-1:0] match_word,
    input  logic [WORD_W-1:0] res_word,
    input  logic [WORD_W-1:0] ea,
    input  logic              is_user,
    output xlate_res_t        res
);

    logic [MID_W-1:0] len_mask;
    logic             tag_ok;
    logic             mid_ok;
    logic             priv_ok;

    // Match decision: exact tag, masked middle bits, privilege valid bit
    always_comb begin
        len_mask = match_word[LEN_HI:LEN_LO];
        tag_ok   = (ea[TAG_HI:TAG_LO] == match_word[TAG_HI:TAG_LO]);
        mid_ok   = ((ea[MID_HI:MID_LO] & ~len_mask) == match_word[MID_HI:MID_LO]);
        priv_ok  = is_user ? match_word[USR_BIT] : match_word[SUP_BIT];
    end

    // Result build: merge physical tag with masked address bits
    always_comb begin
        res.hit  = tag_ok && mid_ok && priv_ok;
        res.wr   = res_word[RW_BIT];
        res.rd   = res_word[RW_BIT] | res_word[RO_BIT];
        res.page = {res_word[TAG_HI:TAG_LO],
                    (ea[MID_HI:MID_LO] & len_mask) | res_word[MID_HI:MID_LO],
                    ea[MID_LO-1:PAGE_LSB]};
    end

endmodule

// File: rtl/bat_pick.sv
// Module: bat_pick
// Fixed-priority selection among N_ENT candidate results: the lowest
// index with its hit flag set wins. With no hit the output is all zero.
module bat_pick
    import bat_xlate_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  xlate_res_t cand [N_ENT],
    output xlate_res_t sel
);

    // Priority scan from highest index down so the lowest index prevails
    always_comb begin
        sel = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (cand[i].hit) begin
                sel = cand[i];
            end
        end
    end

endmodule

// File: rtl/bat_xlate.sv
// Module: bat_xlate (top)
// Block address translation matcher. It holds separate instruction and
// data tables of N_ENT entries and translates one effective address per
// cycle combinationally. Entry words are loaded through a one-word write
// port. Assumes inputs are stable around the sampling clock edge.
module bat_xlate
    import bat_xlate_pkg::*;
#(
    parameter int N_ENT = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_code,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_lower,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] ea,
    input  logic              is_code,
    input  logic              is_user,
    output logic              hit,
    output logic [PAGE_W-1:0] pa_page,
    output logic              rd_ok,
    output logic              wr_ok
);

    logic [WORD_W-1:0] match_w [N_ENT];
    logic [WORD_W-1:0] res_w   [N_ENT];
    xlate_res_t        cand    [N_ENT];
    xlate_res_t        sel;

    bat_regs #(.N_ENT(N_ENT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_code  (wr_code),
        .wr_idx   (wr_idx),
        .wr_lower (wr_lower),
        .wr_data  (wr_data),
        .rd_code  (is_code),
        .match_w  (match_w),
        .res_w    (res_w)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        bat_entry_cmp u_cmp (
            .match_word (match_w[g]),
            .res_word   (res_w[g]),
            .ea         (ea),
            .is_user    (is_user),
            .res        (cand[g])
        );
    end

    bat_pick #(.N_ENT(N_ENT)) u_pick (
        .cand (cand),
        .sel  (sel)
    );

    // Output drive: the picked result goes straight to the ports
    always_comb begin
        hit     = sel.hit;
        pa_page = sel.page;
        rd_ok   = sel.rd;
        wr_ok   = sel.wr;
    end

endmodule

// File: rtl/bat_xlate_chk.sv
// Module: bat_xlate_chk
// Assertion checker bound to bat_xlate. It samples on the rising edge
// and assumes the lookup inputs are stable around that edge.
module bat_xlate_chk
    import bat_xlate_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] ea,
    input logic              hit,
    input logic [PAGE_W-1:0] pa_page,
    input logic              rd_ok,
    input logic              wr_ok
);

    // R1: the cycle after reset releases, the cleared tables cannot hit
    assert_reset_nohit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !hit);

    // R10: a miss drives every result output to zero
    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pa_page == '0 && !rd_ok && !wr_ok));

    // R7: write permission never comes without read permission
    assert_wr_implies_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> rd_ok);

    // R7: any permission implies a hit
    assert_perm_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok || wr_ok) |-> hit);

    // R6: page offset bits within the 128 KiB granule pass through
    assert_low_page_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa_page[MID_LO-PAGE_LSB-1:0] == ea[MID_LO-1:PAGE_LSB]));

endmodule

bind bat_xlate bat_xlate_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ea      (ea),
    .hit     (hit),
    .pa_page (pa_page),
    .rd_ok   (rd_ok),
    .wr_ok   (wr_ok)
);

// File: tb/bat_xlate_test.sv
module bat_xlate_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_ENT      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_code = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_lower = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] ea = '0;
    logic        is_code = 1'b0;
    logic        is_user = 1'b0;
    logic        hit;
    logic [19:0] pa_page;
    logic        rd_ok;
    logic        wr_ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] m_up [2][N_ENT];
    logic [31:0] m_lo [2][N_ENT];

    bat_xlate #(.N_ENT(N_ENT)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: returns {hit, rd, wr, page[19:0]} from the requirements
    function automatic logic [22:0] model(bit code, bit user, logic [31:0] a);
        for (int i = 0; i < N_ENT; i++) begin
            logic [31:0] u;
            logic [31:0] l;
            logic [10:0] bl;
            logic [10:0] mid;
            u  = m_up[code][i];
            l  = m_lo[code][i];
            bl = u[12:2];
            if (a[31:28] == u[31:28] && (a[27:17] & ~bl) == u[27:17] &&
                (user ? u[0] : u[1])) begin
                mid = (a[27:17] & bl) | l[27:17];
                return {1'b1, l[1] | l[0], l[1], l[31:28], mid, a[16:12]};
            end
        end
        return '0;
    endfunction

    task automatic check(string tag, logic [22:0] got, logic [22:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(bit code, int idx, bit lower, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_code = code; wr_idx = idx[1:0];
        wr_lower = lower; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (lower) m_lo[code][idx] = d;
        else       m_up[code][idx] = d;
    endtask

    task automatic look(string tag, bit code, bit user, logic [31:0] a,
                        logic [22:0] exp);
        @(negedge clk);
        ea = a; is_code = code; is_user = user;
        #1;
        check(tag, {hit, rd_ok, wr_ok, pa_page}, exp);
    endtask

    task automatic look_m(string tag, bit code, bit user, logic [31:0] a);
        look(tag, code, user, a, model(code, user, a));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < N_ENT; e++) begin
                m_up[s][e] = '0; m_lo[s][e] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared tables never hit
        look("R1 reset data sup", 1'b0, 1'b0, 32'h0000_0000, '0);
        look("R1 reset code usr", 1'b1, 1'b1, 32'h0001_2000, '0);

        // R2/R3/R6: data entry 0, tag 8, 128 KiB, supervisor, RW
        do_write(1'b0, 0, 1'b0, 32'h8002_0002);
        do_write(1'b0, 0, 1'b1, 32'h3004_0002);
        look("R2 R6 basic hit", 1'b0, 1'b0, 32'h8003_5678,
             {3'b111, 20'h30055});
        look("R3 tag mismatch", 1'b0, 1'b0, 32'h9003_5678, '0);
        // R5: user access needs bit 0
        look("R5 user denied", 1'b0, 1'b1, 32'h8003_5678, '0);
        // R9: instruction table still empty
        look("R9 code set empty", 1'b1, 1'b0, 32'h8003_5678, '0);

        // R4: entry 1 with 1 MiB mask (bits 4:2 set), read-only
        do_write(1'b0, 1, 1'b0, 32'hA010_001D);
        do_write(1'b0, 1, 1'b1, 32'h5020_0001);
        look("R4 masked hit", 1'b0, 1'b1, 32'hA01C_0ABC,
             {3'b110, 20'h502C0});
        look("R4 unmasked bit differs", 1'b0, 1'b1, 32'hA030_0ABC, '0);

        // R8: entry 2 overlaps entry 0, lower index wins
        do_write(1'b0, 2, 1'b0, 32'h8002_0003);
        do_write(1'b0, 2, 1'b1, 32'hF000_0001);
        look("R8 priority", 1'b0, 1'b0, 32'h8002_1000,
             {3'b111, 20'h30041});
        look("R8 lower usr skips entry0", 1'b0, 1'b1, 32'h8002_1000,
             {3'b110, 20'hF0001});

        // R7: hit without permission
        do_write(1'b1, 3, 1'b0, 32'h4000_0002);
        do_write(1'b1, 3, 1'b1, 32'h1000_0000);
        look("R7 no perm hit", 1'b1, 1'b0, 32'h4001_F000,
             {3'b100, 20'h1001F});
        // R9: data lookup of the code entry misses
        look("R9 data set separate", 1'b0, 1'b0, 32'h4001_F000, '0);
        // R10: empty address space
        look("R10 miss", 1'b0, 1'b0, 32'h7777_7000, '0);

        // Random phase: R6 translation across many entries
        for (int it = 0; it < 600; it++) begin
            if ($urandom_range(0, 2) == 0) begin
                logic [31:0] u;
                logic [11:0] t;
                logic [10:0] bl;
                logic [31:0] r;
                int k;
                k  = $urandom_range(0, 11);
                t  = (12'd1 << k) - 12'd1;
                bl = t[10:0];
                r  = $urandom;
                u  = {r[29:28], r[1:0], r[27:17] & ~bl, r[16:13], bl,
                      ($urandom_range(0, 3) == 0) ? 2'b00 : r[5:4]};
                do_write(r[6], $urandom_range(0, N_ENT - 1), 1'b0, u);
                do_write(r[6], $urandom_range(0, N_ENT - 1), 1'b1, $urandom);
            end else begin
                bit c;
                int e;
                logic [31:0] u;
                logic [31:0] r;
                logic [31:0] a;
                c = $urandom_range(0, 1);
                e = $urandom_range(0, N_ENT - 1);
                u = m_up[c][e];
                r = $urandom;
                if ($urandom_range(0, 3) == 0) a = r;
                else a = {u[31:28], u[27:17] | (r[27:17] & u[12:2]), r[16:0]};
                look_m("R6 random", c, $urandom_range(0, 1), a);
            end
        end

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < N_ENT; e++) begin
                m_up[s][e] = '0; m_lo[s][e] = '0;
            end
        look("R1 after re-reset", 1'b0, 1'b0, 32'h8003_5678, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule